// File: doc/BRIEF.md
# FIFO Read-Side Controller with Retransmit

This block runs the read side of a synchronous FIFO. It holds the read pointer and drives the memory read address. It also registers the word read out. The storage array and the write side sit outside the block. The block takes the write pointer as an input and compares it with its own pointer to produce the empty indication. Memory reads are asynchronous: the word at `mem_raddr` is expected on `mem_rdata` within the same cycle.

A retransmit request rewinds the read pointer to location zero, so every word stored since reset can be read again. The latency mode is captured while master reset is high.
- **Zero-latency mode:** the first stored word lands in the output register on the same edge that samples the request.
- **Normal mode:** the output register holds its value on that edge, and the first word comes out on the next read.

Top module: `fifo_rtx_reader`

## Requirements
- R1: While `rst` is high at a rising edge, `rd_ptr` and `dout` become zero; with `wr_ptr` zero, `empty` is then high.
- R2: The latency mode is taken from `lat_mode_n` only at edges where `rst` is high: 0 selects zero latency and 1 selects normal latency. Changes of `lat_mode_n` outside reset have no effect on later retransmits.
- R3: When `rd_en` is high, `rt_n` is high and `empty` is low at an edge, `dout` takes the word at address `rd_ptr[ADDR_W-1:0]` and `rd_ptr` increments by one.
- R4: A read with `empty` high leaves `dout` and `rd_ptr` unchanged.
- R5: `rt_n` low at an edge sets `rd_ptr` to 0 in normal mode. It does the same in zero-latency mode when `wr_ptr` is 0.
- R6: In zero-latency mode, `rt_n` low at an edge with `wr_ptr` nonzero loads the word at location 0 into `dout` on that edge and sets `rd_ptr` to 1.
- R7: In normal mode, `dout` is unchanged on the retransmit edge. The next read returns the word at location 0.
- R8: `empty` is high exactly when `rd_ptr` equals `wr_ptr` over all ADDR_W+1 bits. After a retransmit, words already read become readable again.
- R9: A retransmit request takes priority over a read enable on the same edge. The read is dropped and the retransmit behaves as in R5–R7.
- R10: `mem_raddr` is 0 while `rt_n` is low; otherwise it equals `rd_ptr[ADDR_W-1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high master reset |
| lat_mode_n | input | 1 | Retransmit latency select, captured in reset (0 = zero latency) |
| rd_en | input | 1 | Read enable |
| rt_n | input | 1 | Active-low retransmit request |
| wr_ptr | input | ADDR_W+1 | Write pointer from the write side |
| mem_rdata | input | DATA_W | Asynchronous read data from the array |
| mem_raddr | output | ADDR_W | Memory read address |
| rd_ptr | output | ADDR_W+1 | Read pointer, for flag logic |
| dout | output | DATA_W | Registered output word |
| empty | output | 1 | No unread word |

## Verification
Every cycle, the assertions check the following:
- the pointer after a rewind in each mode;
- the pointer's single-step advance on a read and its hold on an empty read;
- the output register holding in normal mode and loading in zero-latency mode on a rewind edge;
- the captured mode staying constant outside reset.

Only the bench scenarios can show the rest:
- that the data read after a rewind is the stored sequence in order;
- that the empty indication clears again once previously read data is rewound;
- that toggling the mode pin after reset changes nothing;
- that a simultaneous read is dropped in favour of the rewind.

The bench model runs alongside and compares `dout`, `rd_ptr`, `empty` and `mem_raddr` every cycle.

// File: rtl/rtx_pkg.sv
package rtx_pkg;
  typedef enum logic {
    RTX_LAT_ZERO   = 1'b0,
    RTX_LAT_NORMAL = 1'b1
  } rtx_lat_e;
endpackage

// File: rtl/rtx_mode_latch.sv
module rtx_mode_latch
  import rtx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     lat_mode_n,
  output rtx_lat_e mode
);
  always_ff @(posedge clk) begin
    if (rst) mode <= lat_mode_n ? RTX_LAT_NORMAL : RTX_LAT_ZERO;
  end

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(mode));
endmodule

// File: rtl/rtx_ptr_ctrl.sv
module rtx_ptr_ctrl
  import rtx_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  rtx_lat_e         mode,
  input  logic             rd_en,
  input  logic             rt_n,
  input  logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [ADDR_W-1:0] raddr,
  output logic             empty,
  output logic             ld_head,
  output logic             ld_read
);
  logic rt_fire, has_head;

  assign rt_fire  = !rt_n;
  assign has_head = (wr_ptr != '0);
  assign empty    = (rd_ptr == wr_ptr);
  assign ld_head  = rt_fire && (mode == RTX_LAT_ZERO) && has_head;
  assign ld_read  = !rt_fire && rd_en && !empty;
  assign raddr    = rt_fire ? '0 : rd_ptr[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)          rd_ptr <= '0;
    else if (ld_head) rd_ptr <= PTR_W'(1);
    else if (rt_fire) rd_ptr <= '0;
    else if (ld_read) rd_ptr <= rd_ptr + PTR_W'(1);
  end

  // R5
  rewind_norm_chk: assert property (@(posedge clk) disable iff (rst)
    (!rt_n && (mode == RTX_LAT_NORMAL)) |=> (rd_ptr == '0));
  // R6
  rewind_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!rt_n && (mode == RTX_LAT_ZERO) && (wr_ptr != '0)) |=> (rd_ptr == PTR_W'(1)));
  // R4
  empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rt_n && empty) |=> $stable(rd_ptr));
  // R3
  read_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rt_n && rd_en && !empty) |=> (rd_ptr == $past(rd_ptr) + PTR_W'(1)));
endmodule

// File: rtl/rtx_out_reg.sv
module rtx_out_reg
  import rtx_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  rtx_lat_e          mode,
  input  logic              rt_n,
  input  logic              ld_head,
  input  logic              ld_read,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)                    dout <= '0;
    else if (ld_head || ld_read) dout <= mem_rdata;
  end

  // R7
  norm_rt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rt_n && (mode == RTX_LAT_NORMAL)) |=> $stable(dout));
  // R6
  zero_rt_load_chk: assert property (@(posedge clk) disable iff (rst)
    ld_head |=> (dout == $past(mem_rdata)));
endmodule

// File: rtl/fifo_rtx_reader.sv
module fifo_rtx_reader
  import rtx_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 4,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lat_mode_n,
  input  logic              rd_en,
  input  logic              rt_n,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic [DATA_W-1:0] dout,
  output logic              empty
);
  rtx_lat_e mode;
  logic     ld_head, ld_read;

  rtx_mode_latch u_mode (
    .clk(clk), .rst(rst), .lat_mode_n(lat_mode_n), .mode(mode)
  );

  rtx_ptr_ctrl #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst(rst), .mode(mode), .rd_en(rd_en), .rt_n(rt_n),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .raddr(mem_raddr), .empty(empty),
    .ld_head(ld_head), .ld_read(ld_read)
  );

  rtx_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .mode(mode), .rt_n(rt_n), .ld_head(ld_head),
    .ld_read(ld_read), .mem_rdata(mem_rdata), .dout(dout)
  );

  // R9
  rt_over_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!rt_n && rd_en) |=> (rd_ptr <= PTR_W'(1)));
endmodule

// File: tb/fifo_rtx_reader_test.sv
module fifo_rtx_reader_test;
  localparam int DW = 18;
  localparam int AW = 4;
  localparam int PW = AW + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lat_mode_n = 1'b1;
  logic          rd_en = 1'b0;
  logic          rt_n = 1'b1;
  logic [PW-1:0] wr_ptr = '0;
  logic [DW-1:0] mem [2**AW];
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] mem_raddr;
  logic [PW-1:0] rd_ptr;
  logic [DW-1:0] dout;
  logic          empty;

  int tests = 0;
  int fails = 0;

  logic [PW-1:0] m_ptr = '0;
  logic [DW-1:0] m_dout = '0;
  logic          m_zl = 1'b0;
  string         m_tag = "R1";

  always #4 clk = ~clk;

  assign mem_rdata = mem[mem_raddr];

  fifo_rtx_reader #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .lat_mode_n(lat_mode_n), .rd_en(rd_en), .rt_n(rt_n),
    .wr_ptr(wr_ptr), .mem_rdata(mem_rdata), .mem_raddr(mem_raddr),
    .rd_ptr(rd_ptr), .dout(dout), .empty(empty)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, advanced on each edge and compared shortly after
  always @(posedge clk) begin
    if (rst) begin
      m_ptr = '0; m_dout = '0; m_zl = !lat_mode_n; m_tag = "R1";
    end else if (!rt_n) begin
      if (m_zl && wr_ptr != '0) begin
        m_dout = mem[0]; m_ptr = 1; m_tag = rd_en ? "R9" : "R6";
      end else begin
        m_ptr = '0; m_tag = rd_en ? "R9" : (m_zl ? "R5" : "R7");
      end
    end else if (rd_en && m_ptr != wr_ptr) begin
      m_dout = mem[m_ptr[AW-1:0]]; m_ptr = m_ptr + 1'b1; m_tag = "R3";
    end else if (rd_en) begin
      m_tag = "R4";
    end else begin
      m_tag = "R3";
    end
    #2;
    chk(m_tag, 32'(dout), 32'(m_dout));
    chk(m_tag, 32'(rd_ptr), 32'(m_ptr));
    chk("R8", 32'(empty), 32'(m_ptr == wr_ptr));
    chk("R10", 32'(mem_raddr), rt_n ? 32'(m_ptr[AW-1:0]) : 32'd0);
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_en = 1'b0; rt_n = 1'b1;
    end
  endtask

  task automatic put(logic [DW-1:0] w);
    @(negedge clk);
    rd_en = 1'b0; rt_n = 1'b1;
    mem[wr_ptr[AW-1:0]] = w;
    wr_ptr = wr_ptr + 1'b1;
  endtask

  task automatic rd(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_en = 1'b1; rt_n = 1'b1;
    end
  endtask

  task automatic rt(logic with_rd);
    @(negedge clk);
    rd_en = with_rd; rt_n = 1'b0;
  endtask

  task automatic do_reset(logic mode_n);
    @(negedge clk);
    rst = 1'b1; lat_mode_n = mode_n; rd_en = 1'b0; rt_n = 1'b1; wr_ptr = '0;
    idle(2);
    @(negedge clk);
    rst = 1'b0; lat_mode_n = ~mode_n;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2**AW; i++) mem[i] = DW'(18'h3F000 + i);
    // normal latency
    do_reset(1'b1);
    idle(1);
    chk("R1", 32'(dout), 32'd0);
    chk("R1", 32'(empty), 32'd1);
    rd(2);                                  // R4: reads on empty
    for (int i = 0; i < 6; i++) put(DW'(18'h100 * (i + 1) + i));
    rd(4);
    rt(1'b0);                               // R7: hold on rewind
    idle(1);
    chk("R7", 32'(dout), 32'(mem[3]));
    rd(1);
    idle(1);
    chk("R7", 32'(dout), 32'(mem[0]));
    rd(2);
    rt(1'b1);                               // R9
    rd(8);                                  // drains and overreads (R4)
    idle(1);
    chk("R4", 32'(dout), 32'(mem[5]));
    rt(1'b0);
    idle(1);
    chk("R8", 32'(empty), 32'd0);           // data readable again
    rd(3);
    idle(1);
    // zero latency
    do_reset(1'b0);
    rt(1'b0);                               // R5: nothing stored
    idle(1);
    chk("R5", 32'(rd_ptr), 32'd0);
    chk("R5", 32'(dout), 32'd0);
    for (int i = 0; i < 5; i++) put(DW'(18'h2A0 + 7 * i));
    rd(3);
    rt(1'b0);
    @(posedge clk); #3;
    chk("R6", 32'(dout), 32'(mem[0]));
    chk("R6", 32'(rd_ptr), 32'd1);
    rd(1);
    idle(1);
    chk("R6", 32'(dout), 32'(mem[1]));
    lat_mode_n = 1'b0; idle(1); lat_mode_n = 1'b1;  // R2: outside reset
    rd(2);
    rt(1'b0);
    idle(1);
    chk("R2", 32'(dout), 32'(mem[0]));
    rt(1'b1);                               // R9 in zero latency
    idle(1);
    chk("R9", 32'(rd_ptr), 32'd1);
    rd(6);
    idle(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule